// File: doc/BRIEF.md
# Five-Point Neighbourhood Smoothing Engine

This block filters a small square image held in external memory. For every pixel it fetches the four edge-adjacent neighbours and then the pixel itself. It then writes one filtered value: the smallest of the five, the largest of the five, or a two-stage truncating mean. The image is treated as a torus, so a neighbour that would fall off one edge is taken from the opposite edge. Pixels are visited in ascending address order, starting at zero.

The engine talks to memory through a simple strobe interface. It has a pixel address, a bank select, an active-high read strobe and an active-low write strobe. It also has a direction level, a write data bus and a read data bus. Reads always use the source bank and writes always use the destination bank. Because of this, every result is computed from unfiltered data. A start pulse launches a pass over the whole image with the mode sampled at that moment. A one-cycle done pulse ends the pass.

Top module: `nbr_smooth_engine`

## Requirements
- R1: After reset and before any start, the read strobe is low, the write strobe is high, the direction level is high and done is low.
- R2: Exactly five read-strobe cycles precede each write-strobe cycle.
- R3: For a centre address with row in bits 7:4 and column in bits 3:0, the five reads fetch, in this order: column+1, row-1, column-1, row+1, and then the centre. Rows and columns wrap modulo 16, so centre 0x00 reads 0x01, 0xF0, 0x0F, 0x10, 0x00.
- R4: With mode 2'b00, the value written is the minimum of the five values read.
- R5: With mode 2'b01, the value written is the maximum of the five values read.
- R6: With mode 2'b10 or 2'b11, the value written is ((sum of the four neighbours >> 2) + centre) >> 1. Both shifts truncate, and no intermediate sum overflows.
- R7: A write holds the write strobe low for exactly one cycle and then high for one cycle. Address and data stay stable over both cycles, and the direction level is low across the write.
- R8: During reads the bank select is 0 and the direction level is high. During writes the bank select is 1.
- R9: Write addresses step by one from 0x00 to 0xFF within a pass.
- R10: Done is high for exactly one cycle, in the cycle after the write to 0xFF. The engine is idle afterwards. A start pulse during a pass has no effect on that pass.
- R11: The running minimum and maximum start from the first value read for each pixel. A minimum over high values, or a maximum over low values, is therefore exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a pass when idle |
| mode_i | input | 2 | 00 min, 01 max, 1x average; sampled at start |
| mem_addr_o | output | 8 | Pixel address {row, column} |
| mem_bank_o | output | 1 | 0 source bank, 1 destination bank |
| mem_rd_o | output | 1 | Read strobe, data sampled at the clock edge ending the cycle |
| mem_wr_n_o | output | 1 | Active-low write strobe |
| mem_rw_o | output | 1 | 1 read direction, 0 write direction |
| mem_wdata_o | output | 8 | Filtered value to write |
| mem_rdata_i | input | 8 | Data from the source bank |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
A tap counter that slips shows up at once as a wrong read address, at the very next read strobe. It also shows up as a read count other than five before the write. A datapath register loaded at the wrong tap corrupts the value of the current pixel, which appears at the next write, seven cycles or fewer after the fault. A centre counter or end-of-pass fault shows up as a skipped or repeated write address, or as a done pulse that arrives early, arrives late, or lasts more than one cycle.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int PIX_W  = 8;
    localparam int NTAPS  = 5;
    localparam int SUM_W  = PIX_W + 2;

    typedef enum logic [1:0] {
        MODE_MIN  = 2'b00,
        MODE_MAX  = 2'b01,
        MODE_AVG  = 2'b10,
        MODE_AVGB = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WLO,
        ST_WHI,
        ST_FIN
    } state_e;

    // fetch order of the five taps
    typedef enum logic [2:0] {
        TAP_RIGHT = 3'd0,
        TAP_UP    = 3'd1,
        TAP_LEFT  = 3'd2,
        TAP_DOWN  = 3'd3,
        TAP_CTR   = 3'd4
    } tap_e;

    typedef struct packed {
        logic [PIX_W-1:0] lo;
        logic [PIX_W-1:0] hi;
        logic [PIX_W-1:0] ctr;
        logic [SUM_W-1:0] sum;
    } acc_t;

    function automatic logic [PIX_W-1:0] two_stage_mean(
        input logic [SUM_W-1:0] nsum,
        input logic [PIX_W-1:0] centre
    );
        logic [PIX_W-1:0] quarter;
        logic [PIX_W:0]   pair;
        quarter = nsum[SUM_W-1:2];
        pair    = {1'b0, quarter} + {1'b0, centre};
        return pair[PIX_W:1];
    endfunction

endpackage

// File: rtl/nbr_addr_gen.sv
module nbr_addr_gen
    import nbr_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 4,
    localparam int AW   = COL_W + ROW_W
) (
    input  logic [AW-1:0] centre_i,
    input  tap_e          tap_i,
    output logic [AW-1:0] addr_o
);

    logic [COL_W-1:0] col, col_inc, col_dec;
    logic [ROW_W-1:0] row, row_inc, row_dec;

    assign col     = centre_i[COL_W-1:0];
    assign row     = centre_i[AW-1:COL_W];
    assign col_inc = col + COL_W'(1);
    assign col_dec = col - COL_W'(1);
    assign row_inc = row + ROW_W'(1);
    assign row_dec = row - ROW_W'(1);

    always_comb begin
        unique case (tap_i)
            TAP_RIGHT: addr_o = {row, col_inc};
            TAP_UP:    addr_o = {row_dec, col};
            TAP_LEFT:  addr_o = {row, col_dec};
            TAP_DOWN:  addr_o = {row_inc, col};
            default:   addr_o = centre_i;
        endcase
    end

endmodule

// File: rtl/nbr_reduce.sv
module nbr_reduce
    import nbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  logic             first_i,
    input  logic             centre_i,
    input  mode_e            mode_i,
    input  logic [PIX_W-1:0] rdata_i,
    output logic [PIX_W-1:0] result_o
);

    acc_t acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (take_i) begin
            if (first_i) begin
                acc.lo  <= rdata_i;
                acc.hi  <= rdata_i;
                acc.sum <= SUM_W'(rdata_i);
            end else begin
                if (rdata_i < acc.lo) acc.lo <= rdata_i;
                if (rdata_i > acc.hi) acc.hi <= rdata_i;
                if (centre_i) acc.ctr <= rdata_i;
                else          acc.sum <= acc.sum + SUM_W'(rdata_i);
            end
        end
    end

    always_comb begin
        unique case (mode_i)
            MODE_MIN: result_o = acc.lo;
            MODE_MAX: result_o = acc.hi;
            default:  result_o = two_stage_mean(acc.sum, acc.ctr);
        endcase
    end

endmodule

// File: rtl/nbr_ctrl.sv
module nbr_ctrl
    import nbr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  mode_e         mode_i,
    output mode_e         mode_o,
    output tap_e          tap_o,
    output logic [AW-1:0] centre_o,
    output logic          reading_o,
    output logic          wr_lo_o,
    output logic          writing_o,
    output logic          done_o
);

    localparam logic [AW-1:0] LAST_PIX = '1;

    state_e        state;
    tap_e          tap;
    mode_e         mode_q;
    logic [AW-1:0] centre;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tap    <= TAP_RIGHT;
            mode_q <= MODE_MIN;
            centre <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    state  <= ST_READ;
                    tap    <= TAP_RIGHT;
                    centre <= '0;
                    mode_q <= mode_i;
                end
                ST_READ: begin
                    if (tap == TAP_CTR) state <= ST_WLO;
                    else                tap   <= tap_e'(tap + 3'd1);
                end
                ST_WLO: state <= ST_WHI;
                ST_WHI: begin
                    if (centre == LAST_PIX) begin
                        state <= ST_FIN;
                    end else begin
                        centre <= centre + AW'(1);
                        tap    <= TAP_RIGHT;
                        state  <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mode_o    = mode_q;
    assign tap_o     = tap;
    assign centre_o  = centre;
    assign reading_o = (state == ST_READ);
    assign wr_lo_o   = (state == ST_WLO);
    assign writing_o = (state == ST_WLO) || (state == ST_WHI);
    assign done_o    = (state == ST_FIN);

endmodule

// File: rtl/nbr_smooth_engine.sv
module nbr_smooth_engine
    import nbr_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [1:0]             mode_i,
    output logic [COL_W+ROW_W-1:0] mem_addr_o,
    output logic                   mem_bank_o,
    output logic                   mem_rd_o,
    output logic                   mem_wr_n_o,
    output logic                   mem_rw_o,
    output logic [PIX_W-1:0]       mem_wdata_o,
    input  logic [PIX_W-1:0]       mem_rdata_i,
    output logic                   done_o
);

    localparam int ADDR_W = COL_W + ROW_W;

    mode_e             mode_q;
    tap_e              tap;
    logic [ADDR_W-1:0] centre, nbr_addr;
    logic              reading, wr_lo, writing;

    nbr_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .mode_i    (mode_e'(mode_i)),
        .mode_o    (mode_q),
        .tap_o     (tap),
        .centre_o  (centre),
        .reading_o (reading),
        .wr_lo_o   (wr_lo),
        .writing_o (writing),
        .done_o    (done_o)
    );

    nbr_addr_gen #(.COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .centre_i (centre),
        .tap_i    (tap),
        .addr_o   (nbr_addr)
    );

    nbr_reduce u_reduce (
        .clk      (clk),
        .rst      (rst),
        .take_i   (reading),
        .first_i  (tap == TAP_RIGHT),
        .centre_i (tap == TAP_CTR),
        .mode_i   (mode_q),
        .rdata_i  (mem_rdata_i),
        .result_o (mem_wdata_o)
    );

    assign mem_addr_o = reading ? nbr_addr : centre;
    assign mem_bank_o = writing;
    assign mem_rd_o   = reading;
    assign mem_wr_n_o = !wr_lo;
    assign mem_rw_o   = !writing;

endmodule

// File: rtl/nbr_smooth_checker.sv
module nbr_smooth_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [1:0]    mode_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_bank_o,
    input logic          mem_rd_o,
    input logic          mem_wr_n_o,
    input logic          mem_rw_o,
    input logic [7:0]    mem_wdata_o,
    input logic [7:0]    mem_rdata_i,
    input logic          done_o
);

    logic [2:0]    rd_cnt;
    logic [AW-1:0] last_wa;
    logic          wa_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt   <= '0;
            last_wa  <= '0;
            wa_valid <= 1'b0;
        end else begin
            if (!mem_wr_n_o)   rd_cnt <= '0;
            else if (mem_rd_o) rd_cnt <= rd_cnt + 3'd1;
            if (!mem_wr_n_o) begin
                last_wa  <= mem_addr_o;
                wa_valid <= 1'b1;
            end else if (done_o) begin
                wa_valid <= 1'b0;
            end
        end
    end

    // R2
    five_reads_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n_o |-> rd_cnt == 3'd5);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && !mem_wr_n_o));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n_o |=> mem_wr_n_o && !mem_rw_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

    // R8
    read_bank_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> !mem_bank_o && mem_rw_o);

    // R8
    write_bank_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n_o |-> mem_bank_o && !mem_rw_o);

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_wr_n_o && wa_valid) |-> mem_addr_o == last_wa + AW'(1));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !mem_rd_o && mem_wr_n_o);

    // R10
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> wa_valid && last_wa == '1);

endmodule

bind nbr_smooth_engine nbr_smooth_checker #(.AW(ADDR_W)) u_chk (.*);

// File: tb/nbr_smooth_engine_test.sv
module nbr_smooth_engine_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_bank, mem_rd, mem_wr_n, mem_rw, done;

    always #2 clk = ~clk;

    nbr_smooth_engine uut (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
        .mem_addr_o(mem_addr), .mem_bank_o(mem_bank), .mem_rd_o(mem_rd),
        .mem_wr_n_o(mem_wr_n), .mem_rw_o(mem_rw), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .done_o(done)
    );

    logic [7:0] src [256];
    assign mem_rdata = mem_rd ? src[mem_addr] : 8'h00;

    typedef struct { int a; int d; } item_t;
    item_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    bit active = 0;
    int pix, rd_idx, wr_cnt, done_seen;
    int cur_mode;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbr(input int c, input int tap);
        int r, q;
        r = c >> 4; q = c & 15;
        case (tap)
            0: return (r << 4) | ((q + 1) & 15);
            1: return (((r + 15) & 15) << 4) | q;
            2: return (r << 4) | ((q + 15) & 15);
            3: return (((r + 1) & 15) << 4) | q;
            default: return c;
        endcase
    endfunction

    function automatic int expect_px(input int c, input int m);
        int v[5];
        int lo, hi, s;
        for (int t = 0; t < 5; t++) v[t] = src[nbr(c, t)];
        lo = v[0]; hi = v[0]; s = 0;
        for (int t = 0; t < 5; t++) begin
            if (v[t] < lo) lo = v[t];
            if (v[t] > hi) hi = v[t];
        end
        for (int t = 0; t < 4; t++) s += v[t];
        if (m == 0) return lo;
        if (m == 1) return hi;
        return ((s >> 2) + v[4]) >> 1;
    endfunction

    function automatic string data_req(input int m);
        if (m == 0) return "R4/R11 min";
        if (m == 1) return "R5/R11 max";
        return "R6 average";
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && active) begin
            if (mem_rd) begin
                check(mem_addr == nbr(pix, rd_idx), "R3 read order", mem_addr, nbr(pix, rd_idx));
                check(!mem_bank && mem_rw, "R8 read bank", {mem_bank, mem_rw}, 1);
                rd_idx++;
            end
            if (!mem_wr_n) begin
                item_t it;
                check(rd_idx == 5, "R2 reads per write", rd_idx, 5);
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected write", mem_addr, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(mem_addr == it.a, "R9 write address", mem_addr, it.a);
                    check(mem_wdata == it.d, data_req(cur_mode), mem_wdata, it.d);
                end
                check(mem_bank && !mem_rw, "R7 write direction", {mem_bank, mem_rw}, 2);
                rd_idx = 0;
                pix++;
                wr_cnt++;
            end
            if (done) begin
                check(wr_cnt == 256, "R10 writes before done", wr_cnt, 256);
                done_seen++;
            end
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic run_frame(input int m);
        exp_q.delete();
        for (int c = 0; c < 256; c++) begin
            item_t it;
            it.a = c;
            it.d = expect_px(c, m);
            exp_q.push_back(it);
        end
        pix = 0; rd_idx = 0; wr_cnt = 0; done_seen = 0;
        cur_mode = m;
        active = 1;
        @(negedge clk);
        mode  = 2'(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode  = 2'(m ^ 1);
        // R10: a start during the pass must not disturb it
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!done && !mem_rd && mem_wr_n, "R10 idle after done", {done, mem_rd, mem_wr_n}, 1);
        check(done_seen == 1, "R10 single done pulse", done_seen, 1);
        check(exp_q.size() == 0, "R9 all pixels written", exp_q.size(), 0);
        repeat (5) @(negedge clk);
        check(!mem_rd && mem_wr_n, "R10 stays idle", {mem_rd, mem_wr_n}, 1);
        active = 0;
    endtask

    initial begin
        #(4 * 100000);
        check(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!mem_rd && mem_wr_n && mem_rw && !done, "R1 reset state",
              {mem_rd, mem_wr_n, mem_rw, done}, 4'b0110);

        // R11 min over high values only
        for (int i = 0; i < 256; i++) src[i] = 8'(8'h80 | ((i * 37 + 11) & 8'h7F));
        run_frame(0);
        // R11 max over low values only
        for (int i = 0; i < 256; i++) src[i] = 8'((i * 53 + 7) & 8'h3F);
        run_frame(1);
        // R6 full-range pattern
        for (int i = 0; i < 256; i++) src[i] = 8'((i * 97 + (i >> 3) * 13) & 8'hFF);
        run_frame(2);
        // R6 mode 11, saturated values to stress the sums
        for (int i = 0; i < 256; i++) src[i] = (i % 7 == 0) ? 8'h01 : 8'hFF;
        run_frame(3);
        finish_up();
    end

endmodule